// File: doc/BRIEF.md
# Serial LED Refresh Controller

This block drives an external daisy chain of serial-in, parallel-out shift registers, most often used to light status LEDs. Software programs a small register file. Whenever an update is requested, the engine sends the enabled part of a 24-bit output word over a serial data line, one bit per shift-clock period, with the most significant enabled bit first. A single-cycle store strobe then moves the chain contents to the register outputs.

Updates come from two sources. Software can request one directly. A rate timer can also request updates on its own, at 2, 4, 8 or 10 Hz, derived from the system clock frequency parameter `CLK_HZ`. The shift clock edge that carries data can be the rising or the falling one. The two lowest output bits can follow an external two-bit status input in place of the software data word. A request that arrives while a frame is being sent is held, and the next frame starts as soon as the current one ends. Any number of such requests collapse into that one extra frame.

The engine is a four-state machine. `ST_IDLE` waits for a request. A request with at least one group enabled takes the `load` transition to `ST_LOW`. A request with no group enabled takes the `empty` transition straight to `ST_STORE`. `ST_LOW` is the first half of a bit, and `half_done` moves it to `ST_HIGH`. `ST_HIGH` is the second half of a bit. `half_done` returns it to `ST_LOW` while bits remain, or moves it to `ST_STORE` after the last bit. `ST_STORE` drives the strobe for one cycle and always returns to `ST_IDLE`.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, all five registers read as zero, `led_sclk` and `led_sdat` are low, and no store strobe is driven.
- R2: Reads return the last value written at byte offsets 0x00 (line control), 0x04 (timing control), 0x08 (software data), 0x0C and 0x10 (plain storage). Any other offset reads zero.
- R3: Output group enables sit in timing control: bit 0 enables output bits 15:0 and bit 1 enables output bits 23:16. An update sends the enabled bits most significant first. It produces exactly one active shift-clock edge per bit and then a store strobe exactly one cycle wide.
- R4: Line control bit 26 selects the active shift-clock edge: 0 for rising with an idle low clock, 1 for falling with an idle high clock. Serial data is low outside frames.
- R5: When line control bits 25:24 equal 2'b11, output bits 1:0 take the value of `status_in[1:0]` sampled when the frame starts. Any other value of those bits sends software data bits 1:0.
- R6: A write to line control with bit 31 set requests one update. A write with bit 31 clear requests none.
- R7: When timing control bits 31:30 equal 2'b10, updates repeat every `CLK_HZ/f` cycles. Rate code bits 26:23 select f: 0 gives 2 Hz, 1 gives 4 Hz, 2 gives 8 Hz, and 3 or above gives 10 Hz. Any other trigger value stops periodic updates.
- R8: Requests that arrive while a frame is in progress produce exactly one further frame after it. That frame uses the data present when it starts.
- R9: An update with both groups disabled produces a store strobe and no shift-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| status_in | input | 2 | Hardware status bits that can replace output bits 1:0 |
| led_sclk | output | 1 | Shift clock to the external chain |
| led_sdat | output | 1 | Serial data to the external chain |
| led_store | output | 1 | One-cycle strobe that latches the chain |

## Verification
A wrong bit counter or a wrong group decode shows up in the very next frame. The bench counts the active clock edges between strobes and finds one edge too many or too few, or finds the word latched in the chain shifted by a position. A stuck or wrong state in the state machine shows within one frame as a strobe wider than a cycle, a clock resting at the wrong level, or a missing strobe. A fault in the pending flag or in the rate timer shows only over several frames: as a missing or duplicated frame after back-to-back requests, or as a strobe interval that differs from `CLK_HZ/f` from the third frame onward.

// File: rtl/led_shift_pkg.sv
`timescale 1ns/1ps
package led_shift_pkg;

    localparam int unsigned MAX_BITS  = 24;
    localparam int unsigned GRP0_BITS = 16;
    localparam int unsigned HW_BITS   = 2;
    localparam int unsigned DATA_W    = 32;

    localparam logic [7:0] OFS_LINE   = 8'h00;
    localparam logic [7:0] OFS_TIMING = 8'h04;
    localparam logic [7:0] OFS_SWDATA = 8'h08;
    localparam logic [7:0] OFS_SPARE0 = 8'h0C;
    localparam logic [7:0] OFS_SPARE1 = 8'h10;

    localparam int unsigned LINE_KICK_BIT  = 31;
    localparam int unsigned LINE_EDGE_BIT  = 26;
    localparam int unsigned LINE_SRC_LSB   = 24;
    localparam int unsigned TIM_TRIG_LSB   = 30;
    localparam int unsigned TIM_RATE_LSB   = 23;
    localparam int unsigned TIM_GRP0_BIT   = 0;
    localparam int unsigned TIM_GRP1_BIT   = 1;
    localparam logic [1:0]  TRIG_PERIODIC  = 2'b10;
    localparam logic [1:0]  SRC_HARDWARE   = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_STORE = 2'd3
    } eng_state_e;

    typedef struct packed {
        logic                edge_fall;
        logic [1:0]          src_sel;
        logic [1:0]          trig;
        logic [3:0]          rate;
        logic                grp0;
        logic                grp1;
        logic [MAX_BITS-1:0] swdata;
    } cfg_t;

    function automatic int unsigned rate_hz(input int unsigned code);
        case (code)
            0:       return 2;
            1:       return 4;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/led_shift_regs.sv
`timescale 1ns/1ps
module led_shift_regs
    import led_shift_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg,
    output logic              sw_req
);

    logic [DATA_W-1:0] r_line, r_timing, r_swdata, r_spare0, r_spare1;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_line   <= '0;
            r_timing <= '0;
            r_swdata <= '0;
            r_spare0 <= '0;
            r_spare1 <= '0;
            sw_req   <= 1'b0;
        end else begin
            sw_req <= we && hit(addr, OFS_LINE) && wdata[LINE_KICK_BIT];
            if (we) begin
                if (hit(addr, OFS_LINE))   r_line   <= wdata;
                if (hit(addr, OFS_TIMING)) r_timing <= wdata;
                if (hit(addr, OFS_SWDATA)) r_swdata <= wdata;
                if (hit(addr, OFS_SPARE0)) r_spare0 <= wdata;
                if (hit(addr, OFS_SPARE1)) r_spare1 <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit(addr, OFS_LINE))   rdata = r_line;
        if (hit(addr, OFS_TIMING)) rdata = r_timing;
        if (hit(addr, OFS_SWDATA)) rdata = r_swdata;
        if (hit(addr, OFS_SPARE0)) rdata = r_spare0;
        if (hit(addr, OFS_SPARE1)) rdata = r_spare1;
    end

    always_comb begin
        cfg.edge_fall = r_line[LINE_EDGE_BIT];
        cfg.src_sel   = r_line[LINE_SRC_LSB +: 2];
        cfg.trig      = r_timing[TIM_TRIG_LSB +: 2];
        cfg.rate      = r_timing[TIM_RATE_LSB +: 4];
        cfg.grp0      = r_timing[TIM_GRP0_BIT];
        cfg.grp1      = r_timing[TIM_GRP1_BIT];
        cfg.swdata    = r_swdata[MAX_BITS-1:0];
    end

endmodule

// File: rtl/led_shift_timer.sv
`timescale 1ns/1ps
module led_shift_timer
    import led_shift_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned NUM_RATES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [3:0] rate_code,
    output logic       tick
);

    localparam int unsigned CNT_W = $clog2(CLK_HZ / 2 + 1);
    localparam int unsigned SEL_W = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1;

    logic [CNT_W-1:0] lim_tbl [NUM_RATES];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic [SEL_W-1:0] sel;

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign lim_tbl[g] = CNT_W'(CLK_HZ / rate_hz(g) - 1);
    end

    always_comb begin
        if (rate_code >= 4'(NUM_RATES)) sel = SEL_W'(NUM_RATES - 1);
        else                            sel = SEL_W'(rate_code);
        lim = lim_tbl[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= lim) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end

endmodule

// File: rtl/led_shift_engine.sv
`timescale 1ns/1ps
module led_shift_engine
    import led_shift_pkg::*;
#(
    parameter int unsigned NBITS     = 24,
    parameter int unsigned GRP0_W    = 16,
    parameter int unsigned HALF      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             grp0_en,
    input  logic             grp1_en,
    input  logic             edge_fall,
    input  logic [NBITS-1:0] frame,
    output logic             busy,
    output logic             pend,
    output logic             sh_clk,
    output logic             sh_dat,
    output logic             sh_store
);

    localparam int unsigned GRP1_W = NBITS - GRP0_W;
    localparam int unsigned CNT_W  = $clog2(NBITS + 1);
    localparam int unsigned PH_W   = (HALF > 1) ? $clog2(HALF) : 1;

    eng_state_e       state_q, state_d;
    logic [NBITS-1:0] shreg_q;
    logic [CNT_W-1:0] left_q;
    logic [PH_W-1:0]  ph_q;
    logic             pend_q;
    logic             go, half_done;
    logic [CNT_W-1:0] nbits;
    logic [NBITS-1:0] aligned;

    assign go        = req | pend_q;
    assign half_done = (ph_q == PH_W'(HALF - 1));
    assign nbits     = (grp0_en ? CNT_W'(GRP0_W) : '0) + (grp1_en ? CNT_W'(GRP1_W) : '0);
    assign aligned   = grp1_en ? frame : {frame[GRP0_W-1:0], {GRP1_W{1'b0}}};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go) state_d = (nbits == '0) ? ST_STORE : ST_LOW;
            ST_LOW:   if (half_done) state_d = ST_HIGH;
            ST_HIGH:  if (half_done) state_d = (left_q == CNT_W'(1)) ? ST_STORE : ST_LOW;
            ST_STORE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            left_q  <= '0;
            ph_q    <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) pend_q <= 1'b0;
            else if (req)           pend_q <= 1'b1;

            if ((state_q == ST_LOW || state_q == ST_HIGH) && !half_done) ph_q <= ph_q + 1'b1;
            else                                                         ph_q <= '0;

            if (state_q == ST_IDLE && go) begin
                shreg_q <= aligned;
                left_q  <= nbits;
            end else if (state_q == ST_HIGH && half_done) begin
                shreg_q <= {shreg_q[NBITS-2:0], 1'b0};
                left_q  <= left_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        sh_clk   = edge_fall;
        sh_dat   = 1'b0;
        sh_store = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_LOW:   sh_dat = shreg_q[NBITS-1];
            ST_HIGH: begin
                sh_dat = shreg_q[NBITS-1];
                sh_clk = ~edge_fall;
            end
            ST_STORE: sh_store = 1'b1;
            default:  ;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign pend = pend_q;

endmodule

// File: rtl/led_shift_ctrl.sv
`timescale 1ns/1ps
module led_shift_ctrl
    import led_shift_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 100_000_000,
    parameter int unsigned SCLK_HALF = 4,
    parameter int unsigned ADDR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [1:0]        status_in,
    output logic              led_sclk,
    output logic              led_sdat,
    output logic              led_store
);

    cfg_t                cfg;
    logic                sw_req, tick, req;
    logic                eng_busy, eng_pend, eng_edge;
    logic [MAX_BITS-1:0] frame;

    led_shift_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .cfg    (cfg),
        .sw_req (sw_req)
    );

    led_shift_timer #(.CLK_HZ(CLK_HZ), .NUM_RATES(4)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.trig == TRIG_PERIODIC),
        .rate_code (cfg.rate),
        .tick      (tick)
    );

    always_comb begin
        frame = cfg.swdata;
        if (cfg.src_sel == SRC_HARDWARE) frame[HW_BITS-1:0] = status_in;
    end

    assign req      = sw_req | tick;
    assign eng_edge = cfg.edge_fall;

    led_shift_engine #(.NBITS(MAX_BITS), .GRP0_W(GRP0_BITS), .HALF(SCLK_HALF)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .grp0_en   (cfg.grp0),
        .grp1_en   (cfg.grp1),
        .edge_fall (eng_edge),
        .frame     (frame),
        .busy      (eng_busy),
        .pend      (eng_pend),
        .sh_clk    (led_sclk),
        .sh_dat    (led_sdat),
        .sh_store  (led_store)
    );

endmodule

// File: rtl/led_shift_checker.sv
`timescale 1ns/1ps
module led_shift_checker (
    input logic clk,
    input logic rst_n,
    input logic sh_clk,
    input logic sh_dat,
    input logic sh_store,
    input logic edge_fall,
    input logic busy,
    input logic pend,
    input logic sw_req
);

    assert_store_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |=> !sh_store);

    assert_store_clk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> (sh_clk == edge_fall) && !sh_dat);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sh_clk == edge_fall) && !sh_dat && !sh_store);

    assert_sw_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_req && !busy) |=> busy);

    assert_pend_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !busy) |=> busy);

endmodule

bind led_shift_ctrl led_shift_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sh_clk    (led_sclk),
    .sh_dat    (led_sdat),
    .sh_store  (led_store),
    .edge_fall (eng_edge),
    .busy      (eng_busy),
    .pend      (eng_pend),
    .sw_req    (sw_req)
);

// File: tb/test_led_shift_ctrl.sv
`timescale 1ns/1ps
module test_led_shift_ctrl;

    localparam int unsigned CLK_HZ = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  status_in = '0;
    logic        led_sclk, led_sdat, led_store;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    led_shift_ctrl #(.CLK_HZ(CLK_HZ), .SCLK_HALF(1), .ADDR_W(5)) i_led_shift_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .status_in(status_in),
        .led_sclk(led_sclk), .led_sdat(led_sdat), .led_store(led_store)
    );

    // external chain model
    logic        m_edge = 1'b0;
    logic        prev_clk = 1'b0;
    logic [23:0] chain = '0;
    logic [23:0] latched = '0;
    int          edges = 0, stores = 0;
    int          cyc = 0, last_store = -1, interval = 0;
    int          wide_store = 0;
    logic        prev_store = 1'b0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (led_sclk != prev_clk && led_sclk == ~m_edge) begin
                chain = {chain[22:0], led_sdat};
                edges++;
            end
            if (led_store) begin
                if (prev_store) wide_store++;
                latched = chain;
                stores++;
                if (last_store >= 0) interval = cyc - last_store;
                last_store = cyc;
            end
        end
        prev_clk   = led_sclk;
        prev_store = led_store;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a[4:0];
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one software-triggered frame, checked against the arithmetic model
    task automatic run_frame(input logic [23:0] data, input logic [1:0] grp,
                             input logic edg, input logic [1:0] src, input logic [1:0] hw);
        logic [23:0] f, expv, mask;
        int n, b_st, b_ed;
        wr(8'h08, {8'h0, data});
        wr(8'h04, {30'h0, grp});
        m_edge = edg;
        status_in = hw;
        idle(2);
        #1 b_st = stores; b_ed = edges;
        wr(8'h00, {1'b1, 4'h0, edg, src, 24'h0});
        for (int i = 0; i < 200 && stores == b_st; i++) @(negedge clk);
        idle(4);
        f = data;
        if (src == 2'b11) f[1:0] = hw;
        case (grp)
            2'b01: begin n = 16; expv = {8'h0, f[15:0]}; end
            2'b10: begin n = 8;  expv = {16'h0, f[23:16]}; end
            2'b11: begin n = 24; expv = f; end
            default: begin n = 0; expv = '0; end
        endcase
        mask = 24'((32'h1 << n) - 1);
        check(stores - b_st == 1, "R6 one store per kick", 32'(stores - b_st), 32'd1);
        if (n == 0) begin
            check(edges == b_ed, "R9 no edges when groups off", 32'(edges - b_ed), 32'd0);
        end else begin
            check(edges - b_ed == n, "R3/R4 active edge count", 32'(edges - b_ed), 32'(n));
            if (src == 2'b11)
                check((latched & mask) == expv, "R5 hw override frame", {8'h0, latched & mask}, {8'h0, expv});
            else
                check((latched & mask) == expv, "R3 frame content", {8'h0, latched & mask}, {8'h0, expv});
        end
    endtask

    initial begin
        logic [31:0] r;
        logic [23:0] pats [4];
        pats[0] = 24'h000001; pats[1] = 24'h800000; pats[2] = 24'h5A3C96; pats[3] = 24'hFFFFFE;

        idle(3);
        #1;
        check(led_sclk == 1'b0 && led_sdat == 1'b0 && led_store == 1'b0, "R1 idle outputs in reset",
              {29'h0, led_sclk, led_sdat, led_store}, 32'h0);
        rst_n = 1'b1;
        idle(2);
        for (int a = 0; a <= 16; a += 4) begin
            rd(8'(a), r);
            check(r == 32'h0, "R1 register reset value", r, 32'h0);
        end
        check(led_sclk == 1'b0 && led_sdat == 1'b0 && led_store == 1'b0, "R1 idle outputs after reset",
              {29'h0, led_sclk, led_sdat, led_store}, 32'h0);

        // R2 readback
        wr(8'h04, 32'h7F00_0003);
        wr(8'h08, 32'hDEAD_BEEF);
        wr(8'h0C, 32'h1234_5678);
        wr(8'h10, 32'hCAFE_F00D);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0300_0000);
        rd(8'h00, r); check(r == 32'h0300_0000, "R2 readback line", r, 32'h0300_0000);
        rd(8'h04, r); check(r == 32'h7F00_0003, "R2 readback timing", r, 32'h7F00_0003);
        rd(8'h08, r); check(r == 32'hDEAD_BEEF, "R2 readback data", r, 32'hDEAD_BEEF);
        rd(8'h0C, r); check(r == 32'h1234_5678, "R2 readback spare0", r, 32'h1234_5678);
        rd(8'h10, r); check(r == 32'hCAFE_F00D, "R2 readback spare1", r, 32'hCAFE_F00D);
        rd(8'h14, r); check(r == 32'h0, "R2 unmapped reads zero", r, 32'h0);

        // R6: write without kick bit starts nothing
        idle(2);
        begin
            int b;
            #1 b = stores;
            wr(8'h00, 32'h0400_0000);
            m_edge = 1'b1;
            idle(100);
            check(stores == b, "R6 no update without kick", 32'(stores - b), 32'h0);
        end

        // near-exhaustive frame sweep
        for (int p = 0; p < 4; p++)
            for (int g = 0; g < 4; g++)
                for (int e = 0; e < 2; e++)
                    for (int s = 0; s < 2; s++)
                        run_frame(pats[p], 2'(g), 1'(e), s ? 2'b11 : 2'b00, 2'(p));
        run_frame(24'h00A5A5, 2'b01, 1'b0, 2'b01, 2'b10);
        run_frame(24'h00A5A6, 2'b01, 1'b1, 2'b10, 2'b01);

        // R8: requests during a frame collapse to one extra frame
        begin
            int b;
            m_edge = 1'b0;
            wr(8'h08, 32'h00AB_CDEF);
            wr(8'h04, 32'h3);
            idle(2);
            #1 b = stores;
            wr(8'h00, 32'h8000_0000);
            idle(3);
            wr(8'h08, 32'h0012_3456);
            wr(8'h00, 32'h8000_0000);
            wr(8'h00, 32'h8000_0000);
            idle(300);
            check(stores - b == 2, "R8 exactly one extra frame", 32'(stores - b), 32'd2);
            check(latched == 24'h123456, "R8 pending frame uses new data", {8'h0, latched}, 32'h0012_3456);
        end

        // R7: periodic rates
        for (int code = 0; code < 6; code++) begin
            int hz, b;
            hz = (code == 0) ? 2 : (code == 1) ? 4 : (code == 2) ? 8 : 10;
            wr(8'h04, (32'h2 << 30) | (32'(code) << 23) | 32'h1);
            #1 b = stores;
            for (int i = 0; i < 4 * CLK_HZ && stores < b + 3; i++) @(negedge clk);
            check(interval == CLK_HZ / hz, "R7 periodic interval", 32'(interval), 32'(CLK_HZ / hz));
        end
        wr(8'h04, 32'h4000_0001);
        idle(100);
        begin
            int b;
            #1 b = stores;
            idle(500);
            check(stores == b, "R7 no periodic with other trigger", 32'(stores - b), 32'h0);
        end
        check(wide_store == 0, "R3 store strobe one cycle", 32'(wide_store), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule